// File: doc/BRIEF.md
# Dual Halfword Multiply-Accumulate Unit

This block is a pipelined arithmetic unit for signal-processing code that works on pairs of signed 16-bit samples packed into 32-bit words. It multiplies the two signed halves of operand A by the two signed halves of operand B. The halves of B can be swapped before the multiply. The two products are then added or subtracted. The combined value can be returned as it is, added to a 32-bit accumulator, or added to a 64-bit accumulator. One further mode returns the upper word of a full signed 32×32 product, with or without a 32-bit addend.

A request is presented by raising `start` for one cycle with the opcode, the exchange bit, both operands and the accumulator. Exactly two cycles later the 64-bit result appears with `res_valid`. A new request may be issued every cycle. Every mode whose result is 32 bits wide wraps modulo 2^32 and updates a sticky overflow flag, which only reset clears.

Top module: `dual_mac_unit`

## Requirements
- R1: Opcode 0 returns A[15:0]*B[15:0] + A[31:16]*B[31:16], with every half treated as signed, wrapped to 32 bits (0xFFFDFFFF with 0x00040002 gives 0xFFFFFFF2).
- R2: Opcodes 1, 3 and 5 subtract the high-half product from the low-half product instead of adding it (0x00030006 with 0x00050004 and addend 0x800 in opcode 3 gives 0x809).
- R3: When `xchg` is 1 in opcodes 0 to 5, B[15:0] and B[31:16] are swapped before multiplying (0x00030002 with 0x00050004 and addend 0x800 in opcode 2 gives 0x816).
- R4: Opcodes 2 and 3 add acc_in[31:0] as a signed value to the dual result, wrapped modulo 2^32 (0x00030002 with 0x00050004 and addend 0x20000000 gives 0x20000017).
- R5: Opcodes 4 and 5 add the sign-extended dual result to all 64 bits of acc_in, modulo 2^64, and never touch the overflow flag (addend 0x2_00000000 gives 0x2_00000017).
- R6: Opcode 6 returns bits 63:32 of the signed 64-bit product A*B plus acc_in[31:0], and opcode 7 returns the same word with no addend. `xchg` has no effect on either (0x40000000 × 0x10 with addend 0x300 gives 0x304).
- R7: In every opcode except 4 and 5, result[63:32] is the sign extension of result[31:0].
- R8: `res_valid` is high in exactly the cycles that come two cycles after a cycle with `start` high, and `start` is accepted in every cycle.
- R9: `ovf_flag` is set when the exact signed value of a 32-bit-mode result lies outside [-2^31, 2^31-1]. It then stays set until reset.
- R10: Reset clears `res_valid`, `result` and `ovf_flag` to 0. `result` holds its last value in every cycle that brings no new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Issues a request this cycle |
| op | input | 3 | Opcode 0..7 (see R1 to R6) |
| xchg | input | 1 | Swap the halves of B in the dual modes |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| acc_in | input | 64 | Accumulator or addend |
| res_valid | output | 1 | Result valid strobe |
| result | output | 64 | Result word |
| ovf_flag | output | 1 | Sticky 32-bit overflow flag |

## Verification
The latency assertions assume that reset is not applied while a request is in flight. The bench therefore raises reset only after two idle cycles with `start` low. The overflow assertions assume that every opcode value is legal, which holds because all eight codes are defined. The stimulus sweeps the halfword corner values 0, 1, 3, -1, 0x7FFF and 0x8000 across all four operand halves, all opcodes, both exchange settings and a rotating set of accumulators, and issues them back to back, so the pipeline is exercised at full rate.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [2:0] {
    OP_DSUM     = 3'd0,
    OP_DDIF     = 3'd1,
    OP_DSUM_A32 = 3'd2,
    OP_DDIF_A32 = 3'd3,
    OP_DSUM_A64 = 3'd4,
    OP_DDIF_A64 = 3'd5,
    OP_TOPW_A32 = 3'd6,
    OP_TOPW     = 3'd7
  } dmac_op_e;

  function automatic logic op_is_topw(input dmac_op_e op);
    return (op == OP_TOPW_A32) || (op == OP_TOPW);
  endfunction

  function automatic logic op_is_long(input dmac_op_e op);
    return (op == OP_DSUM_A64) || (op == OP_DDIF_A64);
  endfunction

  function automatic logic op_is_sub(input dmac_op_e op);
    return (op == OP_DDIF) || (op == OP_DDIF_A32) || (op == OP_DDIF_A64);
  endfunction

  function automatic logic op_adds_acc32(input dmac_op_e op);
    return (op == OP_DSUM_A32) || (op == OP_DDIF_A32) || (op == OP_TOPW_A32);
  endfunction

endpackage

// File: rtl/dmac_mul_stage.sv
module dmac_mul_stage
  import dmac_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  dmac_op_e                      op,
  input  logic                          xchg,
  input  logic [2*HALF_W-1:0]           opa,
  input  logic [2*HALF_W-1:0]           opb,
  input  logic [4*HALF_W-1:0]           acc_in,
  output logic                          s1_valid,
  output dmac_op_e                      s1_op,
  output logic signed [2*HALF_W-1:0]    s1_plo,
  output logic signed [2*HALF_W-1:0]    s1_phi,
  output logic signed [2*HALF_W-1:0]    s1_msw,
  output logic [4*HALF_W-1:0]           s1_acc
);
  localparam int PW     = 2 * HALF_W;
  localparam int WORD_W = 2 * HALF_W;
  localparam int ACC_W  = 2 * WORD_W;
  localparam int LANES  = 2;

  function automatic logic signed [PW-1:0] half_mul(
    input logic signed [HALF_W-1:0] x,
    input logic signed [HALF_W-1:0] y);
    logic signed [PW-1:0] xe, ye;
    xe = PW'(x);
    ye = PW'(y);
    return xe * ye;
  endfunction

  function automatic logic signed [WORD_W-1:0] wide_msw(
    input logic signed [WORD_W-1:0] x,
    input logic signed [WORD_W-1:0] y);
    logic signed [ACC_W-1:0] xe, ye, full;
    xe   = ACC_W'(x);
    ye   = ACC_W'(y);
    full = xe * ye;
    return full[ACC_W-1:WORD_W];
  endfunction

  logic signed [PW-1:0]     lane_prod [LANES];
  logic signed [WORD_W-1:0] top_word;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [HALF_W-1:0] a_part;
    logic signed [HALF_W-1:0] b_part;
    assign a_part       = opa[g*HALF_W +: HALF_W];
    assign b_part       = xchg ? opb[(LANES-1-g)*HALF_W +: HALF_W]
                               : opb[g*HALF_W +: HALF_W];
    assign lane_prod[g] = half_mul(a_part, b_part);
  end

  assign top_word = wide_msw(opa, opb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_op    <= OP_DSUM;
      s1_plo   <= '0;
      s1_phi   <= '0;
      s1_msw   <= '0;
      s1_acc   <= '0;
    end else begin
      s1_valid <= start;
      if (start) begin
        s1_op  <= op;
        s1_plo <= lane_prod[0];
        s1_phi <= lane_prod[1];
        s1_msw <= top_word;
        s1_acc <= acc_in;
      end
    end
  end

endmodule

// File: rtl/dmac_acc_stage.sv
module dmac_acc_stage
  import dmac_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          s1_valid,
  input  dmac_op_e                      s1_op,
  input  logic signed [2*HALF_W-1:0]    s1_plo,
  input  logic signed [2*HALF_W-1:0]    s1_phi,
  input  logic signed [2*HALF_W-1:0]    s1_msw,
  input  logic [4*HALF_W-1:0]           s1_acc,
  output logic                          res_valid,
  output dmac_op_e                      res_op,
  output logic [4*HALF_W-1:0]           result,
  output logic                          ovf_now,
  output logic                          ovf_flag
);
  localparam int PW     = 2 * HALF_W;
  localparam int DW     = PW + 1;
  localparam int WORD_W = 2 * HALF_W;
  localparam int ACC_W  = 2 * WORD_W;
  localparam int EW     = WORD_W + 2;

  function automatic logic signed [DW-1:0] dual_combine(
    input logic signed [PW-1:0] lo,
    input logic signed [PW-1:0] hi,
    input logic                 sub);
    logic signed [DW-1:0] le, he;
    le = DW'(lo);
    he = DW'(hi);
    return sub ? (le - he) : (le + he);
  endfunction

  function automatic logic word_overflows(input logic [EW-1:0] v);
    return (|v[EW-1:WORD_W-1]) && !(&v[EW-1:WORD_W-1]);
  endfunction

  logic signed [DW-1:0]     dual;
  logic signed [WORD_W-1:0] acc_lo;
  logic signed [EW-1:0]     base, addend, exact;
  logic [ACC_W-1:0]         long_sum, narrow_res, next_res;
  logic                     is_long;

  always_comb begin
    is_long    = op_is_long(s1_op);
    dual       = dual_combine(s1_plo, s1_phi, op_is_sub(s1_op));
    acc_lo     = s1_acc[WORD_W-1:0];
    base       = op_is_topw(s1_op) ? EW'(s1_msw) : EW'(dual);
    addend     = op_adds_acc32(s1_op) ? EW'(acc_lo) : '0;
    exact      = base + addend;
    long_sum   = s1_acc + ACC_W'(dual);
    narrow_res = ACC_W'($signed(exact[WORD_W-1:0]));
    next_res   = is_long ? long_sum : narrow_res;
  end

  assign ovf_now = s1_valid && !is_long && word_overflows(exact);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_op    <= OP_DSUM;
      result    <= '0;
      ovf_flag  <= 1'b0;
    end else begin
      res_valid <= s1_valid;
      if (s1_valid) begin
        res_op <= s1_op;
        result <= next_res;
      end
      if (ovf_now) ovf_flag <= 1'b1;
    end
  end

  AST_OVF_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_now |=> ovf_flag); // R9

endmodule

// File: rtl/dual_mac_unit.sv
module dual_mac_unit
  import dmac_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [2:0]            op,
  input  logic                  xchg,
  input  logic [2*HALF_W-1:0]   opa,
  input  logic [2*HALF_W-1:0]   opb,
  input  logic [4*HALF_W-1:0]   acc_in,
  output logic                  res_valid,
  output logic [4*HALF_W-1:0]   result,
  output logic                  ovf_flag
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int ACC_W  = 2 * WORD_W;

  dmac_op_e                 op_e;
  logic                     s1_valid;
  dmac_op_e                 s1_op;
  logic signed [WORD_W-1:0] s1_plo, s1_phi, s1_msw;
  logic [ACC_W-1:0]         s1_acc;
  dmac_op_e                 res_op;
  logic                     ovf_now;

  assign op_e = dmac_op_e'(op);

  dmac_mul_stage #(.HALF_W(HALF_W)) u_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op       (op_e),
    .xchg     (xchg),
    .opa      (opa),
    .opb      (opb),
    .acc_in   (acc_in),
    .s1_valid (s1_valid),
    .s1_op    (s1_op),
    .s1_plo   (s1_plo),
    .s1_phi   (s1_phi),
    .s1_msw   (s1_msw),
    .s1_acc   (s1_acc)
  );

  dmac_acc_stage #(.HALF_W(HALF_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_valid  (s1_valid),
    .s1_op     (s1_op),
    .s1_plo    (s1_plo),
    .s1_phi    (s1_phi),
    .s1_msw    (s1_msw),
    .s1_acc    (s1_acc),
    .res_valid (res_valid),
    .res_op    (res_op),
    .result    (result),
    .ovf_now   (ovf_now),
    .ovf_flag  (ovf_flag)
  );

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ##1 res_valid); // R8
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ##1 !res_valid); // R8
  AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !op_is_long(res_op)) |->
      (result[ACC_W-1:WORD_W] == {WORD_W{result[WORD_W-1]}})); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(result)); // R10

endmodule

// File: tb/dual_mac_unit_tb_top.sv
module dual_mac_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        xchg = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic [63:0] acc_in = '0;
  logic        res_valid, ovf_flag;
  logic [63:0] result;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // expected-value pipeline: index 0 issued last negedge, 1 two negedges ago
  bit          p_v[2];
  logic [63:0] p_res[2];
  bit          p_ovf[2];
  bit          p_nar[2];
  string       p_tag[2];
  bit          exp_flag;
  logic [63:0] last_res;

  always #5 clk = ~clk;

  dual_mac_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .xchg(xchg),
    .opa(opa), .opb(opb), .acc_in(acc_in),
    .res_valid(res_valid), .result(result), .ovf_flag(ovf_flag)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [2:0] o, input bit x, input logic [31:0] a,
                                input logic [31:0] b, input logic [63:0] c,
                                output logic [63:0] r, output bit ov, output bit nar);
    longint al, ah, bl, bh, e, full;
    bit topw, lng, sub, addc;
    al = longint'($signed(a[15:0]));
    ah = longint'($signed(a[31:16]));
    bl = x ? longint'($signed(b[31:16])) : longint'($signed(b[15:0]));
    bh = x ? longint'($signed(b[15:0]))  : longint'($signed(b[31:16]));
    topw = (o >= 3'd6);
    lng  = (o == 3'd4) || (o == 3'd5);
    sub  = !topw && o[0];
    addc = (o == 3'd2) || (o == 3'd3) || (o == 3'd6);
    if (topw) begin
      full = longint'($signed(a)) * longint'($signed(b));
      e = full >>> 32;
    end else begin
      e = sub ? (al * bl - ah * bh) : (al * bl + ah * bh);
    end
    nar = !lng;
    if (lng) begin
      r  = c + 64'(e);
      ov = 0;
    end else begin
      if (addc) e = e + longint'($signed(c[31:0]));
      r  = {{32{e[31]}}, e[31:0]};
      ov = (e > 64'sd2147483647) || (e < -64'sd2147483648);
    end
  endfunction

  function automatic string tag_of(input logic [2:0] o, input bit x);
    if (x && o < 3'd6) return "R3";
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2, 3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check_out();
    if (p_v[1]) begin
      exp_flag = exp_flag | p_ovf[1];
      chk(res_valid === 1'b1, "R8 valid", {63'd0, res_valid}, 64'd1);
      chk(result === p_res[1], p_tag[1], result, p_res[1]);
      if (p_nar[1])
        chk(result[63:32] === {32{result[31]}}, "R7 sign ext", result, p_res[1]);
      last_res = p_res[1];
    end else begin
      chk(res_valid === 1'b0, "R8 idle valid", {63'd0, res_valid}, 64'd0);
      chk(result === last_res, "R10 held", result, last_res);
    end
    chk(ovf_flag === exp_flag, "R9 flag", {63'd0, ovf_flag}, {63'd0, exp_flag});
  endtask

  task automatic step(input bit go, input logic [2:0] o, input bit x,
                      input logic [31:0] a, input logic [31:0] b, input logic [63:0] c);
    @(negedge clk);
    check_out();
    p_v[1] = p_v[0]; p_res[1] = p_res[0]; p_ovf[1] = p_ovf[0];
    p_nar[1] = p_nar[0]; p_tag[1] = p_tag[0];
    start = go; op = o; xchg = x; opa = a; opb = b; acc_in = c;
    p_v[0] = go;
    if (go) begin
      model(o, x, a, b, c, p_res[0], p_ovf[0], p_nar[0]);
      p_tag[0] = tag_of(o, x);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 3'd0, 0, '0, '0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    start = 0;
    rst_n = 0;
    p_v[0] = 0; p_v[1] = 0;
    exp_flag = 0;
    last_res = '0;
    repeat (3) @(negedge clk);
    chk(res_valid === 1'b0, "R10 reset valid", {63'd0, res_valid}, 64'd0);
    chk(result === 64'd0, "R10 reset result", result, 64'd0);
    chk(ovf_flag === 1'b0, "R10 reset flag", {63'd0, ovf_flag}, 64'd0);
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] hv [6];
    logic [63:0] av [4];
    int k;
    hv[0] = 16'h0000; hv[1] = 16'h0001; hv[2] = 16'hFFFF;
    hv[3] = 16'h7FFF; hv[4] = 16'h8000; hv[5] = 16'h0003;
    av[0] = 64'h0; av[1] = 64'h0000_0000_7FFF_FFFF;
    av[2] = 64'hFFFF_FFFF_8000_0000; av[3] = 64'h1234_5678_9ABC_DEF0;
    p_v[0] = 0; p_v[1] = 0;
    do_reset();

    // worked values, none overflowing; flag must stay 0 (R9)
    step(1, 3'd0, 0, 32'hFFFDFFFF, 32'h00040002, 64'h0);          // R1
    step(1, 3'd2, 0, 32'h00030002, 32'h00050004, 64'h20000000);   // R4
    step(1, 3'd2, 1, 32'h00030002, 32'h00050004, 64'h800);        // R3
    step(1, 3'd3, 0, 32'h00030006, 32'h00050004, 64'h800);        // R2
    step(1, 3'd3, 1, 32'h00030002, 32'h00050004, 64'h800);        // R2 R3
    step(1, 3'd4, 0, 32'h00030002, 32'h00050004, 64'h2_00000000); // R5
    step(1, 3'd4, 0, 32'h00000001, 32'h00000001, 64'hFFFF_FFFF_FFFF_FFFF); // R5 wrap
    step(1, 3'd5, 1, 32'h00030006, 32'h00050004, 64'h2_00000000); // R5
    step(1, 3'd6, 0, 32'h40000000, 32'h00000010, 64'h300);        // R6
    step(1, 3'd6, 1, 32'h40000000, 32'h00000010, 64'h300);        // R6 xchg ignored
    step(1, 3'd6, 0, 32'h00000200, 32'h00000004, 64'h100);        // R6
    step(1, 3'd7, 1, 32'h80000000, 32'h80000000, 64'hFFFF);       // R6 no addend
    idle(3);
    // R9: 32-bit wrap with overflow, then sticky through idle and long ops
    step(1, 3'd2, 0, 32'h00000001, 32'h00000001, 64'h7FFF_FFFF);  // R4 R9
    idle(4);
    step(1, 3'd4, 0, 32'h00010001, 32'h00010001, 64'h5);          // R5
    idle(4);
    do_reset();

    // sweep over halfword corners, all opcodes, both exchange settings (R1-R9 coverage)
    k = 0;
    for (int i0 = 0; i0 < 6; i0++)
      for (int i1 = 0; i1 < 6; i1++)
        for (int i2 = 0; i2 < 6; i2++)
          for (int i3 = 0; i3 < 6; i3++)
            for (int o = 0; o < 8; o++)
              for (int x = 0; x < 2; x++) begin
                step(1, 3'(o), x[0], {hv[i1], hv[i0]}, {hv[i3], hv[i2]}, av[k % 4]);
                k++;
                if ((k % 97) == 0) idle(1);
              end
    idle(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule